// File: doc/BRIEF.md
# Message-Signalled Interrupt Source Lookup

This block sits at the front of an interrupt controller and receives message-signalled interrupt writes, one at a time, over a valid/ready handshake. Each write carries an address, a 16-bit data word and, optionally, the partition number of the device that sent it. The block forms an interrupt source number from the message and checks it against the configured number of sources. If the message carries a partition number, the block also computes where that source's 64-bit entry sits in an in-memory vector table, reads the entry through a simple read port, and confirms that the entry names the same partition.

A message that passes every check leaves the block as a single-cycle trigger carrying the source number. A message that fails a check is dropped, and a single-cycle error pulse shows which check it failed. The table base, the table length, the table enable, the entry size and the source count all come from configuration inputs that the surrounding controller holds steady. The contents of the table and the pending/queued state handling that follows the trigger are not part of this block.

Top module: `msi_src_lookup`

## Requirements
- R1: The source number is the address field `req_addr[19:4]` bitwise-OR-ed with the zero-extended low data bits `req_data[4:0]`. Data bits [15:5] do not affect it. `trig_src` carries this number with every trigger.
- R2: A message whose source number is greater than or equal to `cfg_src_count` is dropped. `err_range` pulses for one cycle, in the cycle after acceptance. No trigger follows and no table read is made.
- R3: An in-range message with `req_has_pe` low makes no table read. `trig_valid` is high for exactly the one cycle after acceptance, whatever the values of `cfg_tbl_en` and `cfg_tbl_len`.
- R4: A message with `req_has_pe` high is dropped when `cfg_tbl_en` is low, and `err_tbl_off` pulses in the cycle after acceptance.
- R5: A message with `req_has_pe` high whose source number is greater than or equal to `cfg_tbl_len` is dropped with an `err_range` pulse in the cycle after acceptance, and no read is made.
- R6: The entry address is `(cfg_tbl_base & ~0xFFF) + src*16`, or `+ src*128` when `cfg_big_entry` is high. It is driven on `mem_rd_addr` from the cycle after acceptance. `mem_rd_en` holds high, with the address stable, until the cycle in which `mem_rd_done` is high.
- R7: The entry is stored big-endian. Byte lane k of `mem_rd_data` (bits 8k+7:8k) holds entry byte k, and byte 0 is the most significant byte. The partition field is bits [15:0] of the entry value, so lane 6 gives bits [15:8] and lane 7 gives bits [7:0]. If this field equals `req_pe`, `trig_valid` pulses in the cycle after `mem_rd_done`.
- R8: If the partition field differs from `req_pe`, the message is dropped and `err_owner` pulses in the cycle after `mem_rd_done`, with no trigger.
- R9: If `mem_rd_err` is high together with `mem_rd_done`, the message is dropped and `err_read` pulses in the cycle after, with no trigger.
- R10: `req_ready` is low from the cycle after a table read starts until the cycle after `mem_rd_done`, so only one request is in flight. Requests that need no read may be accepted in back-to-back cycles.
- R11: After reset, `req_ready` is high and `trig_valid`, `mem_rd_en` and all error pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Message present |
| req_ready | output | 1 | Block can accept a message |
| req_addr | input | 64 | Message address |
| req_data | input | 16 | Message data |
| req_has_pe | input | 1 | Partition number accompanies the message |
| req_pe | input | 16 | Originating partition number |
| cfg_src_count | input | 17 | Number of sources served |
| cfg_tbl_en | input | 1 | Vector table enabled |
| cfg_tbl_len | input | 17 | Number of entries in the table |
| cfg_tbl_base | input | 64 | Table base address (low 12 bits ignored) |
| cfg_big_entry | input | 1 | 128-byte entry stride when high, 16-byte when low |
| mem_rd_en | output | 1 | Read request, held until done |
| mem_rd_addr | output | 64 | Entry byte address |
| mem_rd_done | input | 1 | Read completes this cycle |
| mem_rd_err | input | 1 | Read failed (valid with done) |
| mem_rd_data | input | 64 | Raw entry bytes, lane k = byte k |
| trig_valid | output | 1 | One-cycle trigger for an accepted source |
| trig_src | output | 16 | Source number of the trigger |
| err_range | output | 1 | Source out of bounds |
| err_tbl_off | output | 1 | Lookup needed while the table is disabled |
| err_owner | output | 1 | Partition mismatch |
| err_read | output | 1 | Table read failed |

## Verification
The bench tries messages whose address and data bits overlap, and messages where they do not, so that an OR is told apart from an add or a plain concatenation. It also uses data words with high bits set, which shows that only the low five bits take part. Source numbers just below and exactly at the source count and at the table length separate a "<" check from a "<=" check on each bound. Lookups run with both entry strides, and with entries that match, entries that differ only in the low partition byte, and failed reads. These cases tell the stride choice, the byte order and the three outcomes of a lookup apart. Back-to-back messages that need no read, and a message sent while the table is disabled, separate the direct path from the lookup path.

// File: rtl/msi_lookup_pkg.sv
// Package: shared state type and the byte-order helper for the MSI source lookup.
// Assumes 64-bit table entries.
package msi_lookup_pkg;

    typedef enum logic [0:0] {
        LK_IDLE = 1'b0,
        LK_READ = 1'b1
    } lk_state_e;

    // Reverse byte order of a 64-bit word (big-endian memory to value).
    function automatic logic [63:0] swap_bytes64(input logic [63:0] raw);
        logic [63:0] res;
        for (int k = 0; k < 8; k++) begin
            res[8*k +: 8] = raw[8*(7-k) +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/msi_src_decode.sv
// msi_src_decode: forms the source number from a message and checks it against
// the configured source count. Purely combinational.
// Assumes ADDR_W >= ADDR_LSB + SRC_W and DLO_W <= SRC_W.
module msi_src_decode #(
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 16,
    parameter int SRC_W    = 16,
    parameter int ADDR_LSB = 4,
    parameter int DLO_W    = 5
) (
    input  logic [ADDR_W-1:0] msg_addr,
    input  logic [DATA_W-1:0] msg_data,
    input  logic [SRC_W:0]    src_count,
    output logic [SRC_W-1:0]  src_num,
    output logic              src_in_count
);
    localparam int PAD_W = SRC_W - DLO_W;

    // Source number: address field OR-ed with low data bits.
    always_comb begin
        src_num = msg_addr[ADDR_LSB +: SRC_W] | {{PAD_W{1'b0}}, msg_data[DLO_W-1:0]};
    end

    // Bound check against the configured count.
    always_comb begin
        src_in_count = ({1'b0, src_num} < src_count);
    end

    // Bits that do not take part in the decode.
    logic unused_bits;
    assign unused_bits = ^{msg_addr, msg_data};

endmodule

// File: rtl/msi_entry_addr.sv
// msi_entry_addr: validates a source against the vector table settings and
// computes the byte address of its entry. Purely combinational.
// Assumes the table base is aligned to 2**ALIGN_W bytes after masking.
module msi_entry_addr #(
    parameter int ADDR_W   = 64,
    parameter int SRC_W    = 16,
    parameter int ALIGN_W  = 12,
    parameter int SMALL_SH = 4,
    parameter int BIG_SH   = 7
) (
    input  logic [SRC_W-1:0]  src_num,
    input  logic              tbl_en,
    input  logic [SRC_W:0]    tbl_len,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              big_entry,
    output logic              src_in_len,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int EXT_W = ADDR_W - SRC_W;
    localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << ALIGN_W) - ADDR_W'(1));

    logic [ADDR_W-1:0] src_ext;
    logic [ADDR_W-1:0] offset;

    // Source must fall below the table length field.
    always_comb begin
        src_in_len = ({1'b0, src_num} < tbl_len);
    end

    // Entry offset scaled by the selected stride, added to the masked base.
    always_comb begin
        src_ext    = {{EXT_W{1'b0}}, src_num};
        offset     = big_entry ? (src_ext << BIG_SH) : (src_ext << SMALL_SH);
        entry_addr = (tbl_base & BASE_MASK) + offset;
    end

    // Enable is consumed by the sequencer; kept here for a clear port set.
    logic unused_en;
    assign unused_en = tbl_en;

endmodule

// File: rtl/msi_owner_check.sv
// msi_owner_check: restores the byte order of a fetched entry and compares its
// partition field with the partition carried by the message. Combinational.
// Assumes the field lies inside the 64-bit entry.
module msi_owner_check
    import msi_lookup_pkg::*;
#(
    parameter int PE_W   = 16,
    parameter int PE_LSB = 0
) (
    input  logic [63:0]     raw_entry,
    input  logic [PE_W-1:0] want_pe,
    output logic            pe_match
);
    logic [63:0] entry_val;

    // Big-endian entry to native value, then field compare.
    always_comb begin
        entry_val = swap_bytes64(raw_entry);
        pe_match  = (entry_val[PE_LSB +: PE_W] == want_pe);
    end

    // Remaining entry fields belong to later stages.
    logic unused_fields;
    assign unused_fields = ^entry_val;

endmodule

// File: rtl/msi_src_lookup.sv
// msi_src_lookup: accepts one MSI write at a time, decodes its source, applies
// the range, table and ownership checks, and emits a one-cycle trigger or a
// one-cycle error pulse. Configuration inputs are assumed static while a
// request is in flight; the memory port answers only while mem_rd_en is high.
module msi_src_lookup
    import msi_lookup_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int DATA_W  = 16,
    parameter int SRC_W   = 16,
    parameter int PE_W    = 16,
    parameter int ALIGN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_has_pe,
    input  logic [PE_W-1:0]   req_pe,
    input  logic [SRC_W:0]    cfg_src_count,
    input  logic              cfg_tbl_en,
    input  logic [SRC_W:0]    cfg_tbl_len,
    input  logic [ADDR_W-1:0] cfg_tbl_base,
    input  logic              cfg_big_entry,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_done,
    input  logic              mem_rd_err,
    input  logic [63:0]       mem_rd_data,
    output logic              trig_valid,
    output logic [SRC_W-1:0]  trig_src,
    output logic              err_range,
    output logic              err_tbl_off,
    output logic              err_owner,
    output logic              err_read
);
    lk_state_e         state_q;
    logic [SRC_W-1:0]  src_num;
    logic              src_in_count;
    logic              src_in_len;
    logic [ADDR_W-1:0] entry_addr;
    logic [SRC_W-1:0]  src_q;
    logic [PE_W-1:0]   pe_q;
    logic              pe_match;
    logic              req_fire;

    msi_src_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W)
    ) u_decode (
        .msg_addr    (req_addr),
        .msg_data    (req_data),
        .src_count   (cfg_src_count),
        .src_num     (src_num),
        .src_in_count(src_in_count)
    );

    msi_entry_addr #(
        .ADDR_W(ADDR_W), .SRC_W(SRC_W), .ALIGN_W(ALIGN_W)
    ) u_addr (
        .src_num   (src_num),
        .tbl_en    (cfg_tbl_en),
        .tbl_len   (cfg_tbl_len),
        .tbl_base  (cfg_tbl_base),
        .big_entry (cfg_big_entry),
        .src_in_len(src_in_len),
        .entry_addr(entry_addr)
    );

    msi_owner_check #(
        .PE_W(PE_W)
    ) u_owner (
        .raw_entry(mem_rd_data),
        .want_pe  (pe_q),
        .pe_match (pe_match)
    );

    // Handshake: only the idle state takes a new message.
    always_comb begin
        req_ready = (state_q == LK_IDLE);
        req_fire  = req_valid && req_ready;
        mem_rd_en = (state_q == LK_READ);
    end

    // Sequencer: classify accepted messages and finish table lookups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= LK_IDLE;
            src_q       <= '0;
            pe_q        <= '0;
            mem_rd_addr <= '0;
            trig_valid  <= 1'b0;
            trig_src    <= '0;
            err_range   <= 1'b0;
            err_tbl_off <= 1'b0;
            err_owner   <= 1'b0;
            err_read    <= 1'b0;
        end else begin
            trig_valid  <= 1'b0;
            err_range   <= 1'b0;
            err_tbl_off <= 1'b0;
            err_owner   <= 1'b0;
            err_read    <= 1'b0;
            unique case (state_q)
                LK_IDLE: begin
                    if (req_fire) begin
                        if (!src_in_count) begin
                            err_range <= 1'b1;
                        end else if (!req_has_pe) begin
                            trig_valid <= 1'b1;
                            trig_src   <= src_num;
                        end else if (!cfg_tbl_en) begin
                            err_tbl_off <= 1'b1;
                        end else if (!src_in_len) begin
                            err_range <= 1'b1;
                        end else begin
                            state_q     <= LK_READ;
                            src_q       <= src_num;
                            pe_q        <= req_pe;
                            mem_rd_addr <= entry_addr;
                        end
                    end
                end
                LK_READ: begin
                    if (mem_rd_done) begin
                        state_q <= LK_IDLE;
                        if (mem_rd_err) begin
                            err_read <= 1'b1;
                        end else if (pe_match) begin
                            trig_valid <= 1'b1;
                            trig_src   <= src_q;
                        end else begin
                            err_owner <= 1'b1;
                        end
                    end
                end
                default: state_q <= LK_IDLE;
            endcase
        end
    end

    // R2: an out-of-count source produces a range error and nothing else.
    a_r2_count_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && !src_in_count) |=> (err_range && !trig_valid && !mem_rd_en));

    // R6: the read request holds with a stable address until completion.
    a_r6_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !mem_rd_done) |=> (mem_rd_en && $stable(mem_rd_addr)));

    // R6: every entry address lies on a 16-byte boundary.
    a_r6_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_rd_addr[3:0] == 4'h0));

    // R8: a completed read with a foreign partition gives an ownership error.
    a_r8_owner_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && mem_rd_done && !mem_rd_err && !pe_match) |=> (err_owner && !trig_valid));

    // R9: a failed read gives a read error and no trigger.
    a_r9_read_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && mem_rd_done && mem_rd_err) |=> (err_read && !trig_valid));

    // R10: no new message is taken while a lookup is outstanding.
    a_r10_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready);

    // R3: at most one outcome per cycle.
    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trig_valid, err_range, err_tbl_off, err_owner, err_read}));

endmodule

// File: tb/msi_src_lookup_bench.sv
// Bench for msi_src_lookup: a vector table walked by one loop, then directed
// reset, back-to-back and boundary tests. Memory is modelled inside the tasks.
module msi_src_lookup_bench;

    localparam logic [16:0] SRC_COUNT = 17'h00100;
    localparam logic [16:0] TBL_LEN   = 17'h00080;
    localparam logic [63:0] TBL_BASE  = 64'h0000_1234_5000_0ABC;

    // Expected outcome codes.
    localparam logic [2:0] K_TRIG  = 3'd0;
    localparam logic [2:0] K_RANGE = 3'd1;
    localparam logic [2:0] K_OFF   = 3'd2;
    localparam logic [2:0] K_OWNER = 3'd3;
    localparam logic [2:0] K_RDERR = 3'd4;

    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] data;
        logic        has_pe;
        logic [15:0] pe;
        logic        tbl_en;
        logic        big;
        logic [15:0] mem_pe;
        logic        mem_err;
        logic [2:0]  kind;
        logic [15:0] src;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        // R1 R3: address and data fields without overlap
        '{32'h0000_0120, 16'h0005, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, K_TRIG,  16'h0017},
        // R1: overlapping bit OR-ed, not added
        '{32'h0000_0010, 16'h001F, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, K_TRIG,  16'h001F},
        // R2: count-1 passes
        '{32'h0000_0FF0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, K_TRIG,  16'h00FF},
        // R2: exactly count is dropped
        '{32'h0000_1000, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, K_RANGE, 16'h0100},
        // R3: direct path ignores a disabled table and the length
        '{32'h0000_0FF0, 16'h0001, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, K_TRIG,  16'h00FF},
        // R6 R7: small stride, matching partition
        '{32'h0000_0050, 16'h0000, 1'b1, 16'h1234, 1'b1, 1'b0, 16'h1234, 1'b0, K_TRIG,  16'h0005},
        // R6 R7: big stride, matching partition
        '{32'h0000_0050, 16'h0000, 1'b1, 16'h1234, 1'b1, 1'b1, 16'h1234, 1'b0, K_TRIG,  16'h0005},
        // R5: length-1 passes
        '{32'h0000_07F0, 16'h0000, 1'b1, 16'hBEEF, 1'b1, 1'b1, 16'hBEEF, 1'b0, K_TRIG,  16'h007F},
        // R5: exactly the length is dropped
        '{32'h0000_0800, 16'h0000, 1'b1, 16'hBEEF, 1'b1, 1'b0, 16'hBEEF, 1'b0, K_RANGE, 16'h0080},
        // R4: table disabled on the lookup path
        '{32'h0000_0030, 16'h0000, 1'b1, 16'h0001, 1'b0, 1'b0, 16'h0001, 1'b0, K_OFF,   16'h0003},
        // R8: low partition byte differs
        '{32'h0000_0060, 16'h0000, 1'b1, 16'h1234, 1'b1, 1'b0, 16'h1235, 1'b0, K_OWNER, 16'h0006},
        // R9: read error
        '{32'h0000_0070, 16'h0000, 1'b1, 16'h1234, 1'b1, 1'b0, 16'h1234, 1'b1, K_RDERR, 16'h0007},
        // R1: data bits above [4:0] take no part
        '{32'h0000_0030, 16'hFFE0, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, K_TRIG,  16'h0003},
        // R2: out-of-count with partition makes no read
        '{32'h0000_2000, 16'h0000, 1'b1, 16'h1234, 1'b1, 1'b0, 16'h1234, 1'b0, K_RANGE, 16'h0200}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic        req_has_pe = 1'b0;
    logic [15:0] req_pe = '0;
    logic        cfg_tbl_en = 1'b1;
    logic        cfg_big_entry = 1'b0;
    logic        mem_rd_en;
    logic [63:0] mem_rd_addr;
    logic        mem_rd_done = 1'b0;
    logic        mem_rd_err = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        trig_valid;
    logic [15:0] trig_src;
    logic        err_range;
    logic        err_tbl_off;
    logic        err_owner;
    logic        err_read;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    msi_src_lookup u_msi_src_lookup (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_data     (req_data),
        .req_has_pe   (req_has_pe),
        .req_pe       (req_pe),
        .cfg_src_count(SRC_COUNT),
        .cfg_tbl_en   (cfg_tbl_en),
        .cfg_tbl_len  (TBL_LEN),
        .cfg_tbl_base (TBL_BASE),
        .cfg_big_entry(cfg_big_entry),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_done  (mem_rd_done),
        .mem_rd_err   (mem_rd_err),
        .mem_rd_data  (mem_rd_data),
        .trig_valid   (trig_valid),
        .trig_src     (trig_src),
        .err_range    (err_range),
        .err_tbl_off  (err_tbl_off),
        .err_owner    (err_owner),
        .err_read     (err_read)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string kind_req(input logic [2:0] k);
        case (k)
            K_TRIG:  return "R3/R7";
            K_RANGE: return "R2/R5";
            K_OFF:   return "R4";
            K_OWNER: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Big-endian image of an entry value: lane k holds value byte 7-k (R7).
    function automatic logic [63:0] to_memory(input logic [63:0] val);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = val[8*(7-k) +: 8];
        return r;
    endfunction

    task automatic check_outcome(input logic [2:0] k, input logic [15:0] src, input string tag);
        logic [4:0] exp_v, act_v;
        exp_v = {k == K_TRIG, k == K_RANGE, k == K_OFF, k == K_OWNER, k == K_RDERR};
        act_v = {trig_valid, err_range, err_tbl_off, err_owner, err_read};
        check(act_v == exp_v, kind_req(k), {tag, " outcome"}, 64'(act_v), 64'(exp_v));
        if (k == K_TRIG)
            check(trig_src == src, "R1", {tag, " trig_src"}, 64'(trig_src), 64'(src));
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        string tag;
        bit exp_rd;
        logic [63:0] exp_addr;
        tag = $sformatf("vec%0d", idx);
        exp_rd = v.has_pe && v.tbl_en && ({1'b0, v.src} < SRC_COUNT) && ({1'b0, v.src} < TBL_LEN);
        exp_addr = (TBL_BASE & ~64'hFFF) + (64'(v.src) << (v.big ? 7 : 4));
        @(negedge clk);
        req_addr = 64'(v.addr); req_data = v.data; req_has_pe = v.has_pe; req_pe = v.pe;
        cfg_tbl_en = v.tbl_en; cfg_big_entry = v.big; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_rd_en == exp_rd, "R6", {tag, " read issued"}, 64'(mem_rd_en), 64'(exp_rd));
        if (mem_rd_en) begin
            check(mem_rd_addr == exp_addr, "R6", {tag, " entry address"}, mem_rd_addr, exp_addr);
            check(!req_ready, "R10", {tag, " ready during read"}, 64'(req_ready), 64'(0));
            @(negedge clk);
            check(mem_rd_en && mem_rd_addr == exp_addr, "R6", {tag, " read held"}, mem_rd_addr, exp_addr);
            mem_rd_done = 1'b1; mem_rd_err = v.mem_err;
            mem_rd_data = to_memory({48'h0123_4567_89AB, v.mem_pe});
            @(negedge clk);
            mem_rd_done = 1'b0; mem_rd_err = 1'b0;
            check(req_ready, "R10", {tag, " ready after read"}, 64'(req_ready), 64'(1));
        end
        check_outcome(v.kind, v.src, tag);
        @(negedge clk);
        check(!trig_valid, "R3", {tag, " single-cycle trigger"}, 64'(trig_valid), 64'(0));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check(req_ready && !mem_rd_en, "R11", "ready/read in reset", {62'b0, req_ready, mem_rd_en}, 64'h2);
        check({trig_valid, err_range, err_tbl_off, err_owner, err_read} == 5'b0, "R11", "pulses in reset",
              64'({trig_valid, err_range, err_tbl_off, err_owner, err_read}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !trig_valid, "R11", "after reset release", 64'({req_ready, trig_valid}), 64'h2);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

        // R10 R3: back-to-back direct messages, one trigger per cycle
        @(negedge clk);
        req_has_pe = 1'b0; cfg_tbl_en = 1'b1; req_data = 16'h0000;
        req_addr = 64'h0000_0040; req_valid = 1'b1;
        @(negedge clk);
        check(trig_valid && trig_src == 16'h0004, "R10", "b2b first", 64'(trig_src), 64'h4);
        check(req_ready, "R10", "b2b ready", 64'(req_ready), 64'(1));
        req_addr = 64'h0000_0090;
        @(negedge clk);
        req_valid = 1'b0;
        check(trig_valid && trig_src == 16'h0009, "R10", "b2b second", 64'(trig_src), 64'h9);
        @(negedge clk);
        check(!trig_valid, "R3", "b2b idle", 64'(trig_valid), 64'(0));

        // R5 R2: with partition, count and length both exceeded gives one range pulse
        run_vec('{32'h0001_0000, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b1, 16'h0000, 1'b0, K_RANGE, 16'h1000}, 99);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule